// File: doc/BRIEF.md
# Background Task Run Controller

This block sequences the single lowest-priority task of a small task-based coprocessor. Software programs a 16-bit start address and a control word. The task is armed by a software start write, or by a hardware trigger pulse when triggering is allowed. It launches only when it is enabled and no foreground task is waiting. A launch is a one-cycle request to the execution core that carries the address where execution begins.

While the task runs, a foreground request takes the core away from it. The controller captures the core's program counter into a readable resume register and issues a preempt pulse. When the foreground work drains, it relaunches from the captured address. The running task can lock out preemption with a mask command and drop the lock with an unmask command.

A hardware trigger that arrives while a start is still outstanding is not queued. It raises a sticky overflow flag that only an explicit clear removes. A three-bit status word reports running, locked and overflow.

Top module: `bg_task_ctrl`

## Requirements
- R1: After reset, status is 3'b000, the resume register is 0, and neither launch_valid nor preempt is asserted.
- R2: A launch happens only while the enable bit (control bit 0) is 1, a start is outstanding and fg_pending is low. launch_valid is a one-cycle pulse, and a fresh launch carries the start-address register value.
- R3: Writing 1 to control bit 1 arms a start. While fg_pending stays high, the launch is held back, and it follows once fg_pending drops.
- R4: With the trigger-allow bit (control bit 2) set, a hw_trig pulse arms a start exactly as a software start does. With the bit clear, hw_trig has no effect on status or launches.
- R5: An allowed hw_trig that arrives while a start is outstanding and the task is not finishing in that cycle sets the overflow bit (status bit 2).
- R6: The overflow bit stays set until a control write with bit 3 equal to 1. Other control writes leave it unchanged, and a set in the same cycle as the clear wins.
- R7: Status bit 0 (running) is 1 from the cycle launch_valid is seen until the cycle after the task-done pulse, and it stays 1 while the task is preempted.
- R8: mask_cmd while running sets status bit 1. While that bit is 1, fg_pending never causes preemption. unmask_cmd or task_done clears it.
- R9: When fg_pending is high, the task is running and status bit 1 is 0, the block pulses preempt once and loads core_pc into active_addr.
- R10: A preempted task relaunches once fg_pending is low and enable is 1, with launch_addr equal to active_addr.
- R11: task_done ends the run and withdraws the outstanding start, so no further launch happens without a new start.
- R12: A write with wr_sel 0 loads all 16 bits of the start address, which is used by the next fresh launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the start address, 1 selects the control word |
| wr_data | input | 16 | Write data; control word bits: 0 enable, 1 start, 2 trigger allow, 3 overflow clear |
| fg_pending | input | 1 | A foreground task is waiting |
| hw_trig | input | 1 | Hardware trigger pulse |
| task_done | input | 1 | The core finished the background task |
| mask_cmd | input | 1 | Running task locks out preemption |
| unmask_cmd | input | 1 | Running task releases the lock |
| core_pc | input | 16 | Current program counter of the core |
| launch_valid | output | 1 | One-cycle launch request |
| launch_addr | output | 16 | Address at which the core starts or resumes |
| preempt | output | 1 | One-cycle request to suspend the background task |
| status | output | 3 | {overflow, locked, running} |
| active_addr | output | 16 | Program counter captured at the last preemption |

## Verification
A wrong internal state shows at the ports within one or two cycles. A lost or stuck start shows up as a missing or extra launch_valid pulse two cycles after the stimulus. A bad run or lock state shows up as a preempt pulse that should not occur, or one that is missing, on the cycle after fg_pending rises. A corrupted resume address appears both on active_addr and on the launch_addr of the next resume. A cycle-accurate model in the bench compares launch, preempt, status and active_addr on every clock, so any divergence is reported on the first cycle it becomes visible.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HELD = 2'd2} bgt_state_e;

  // control word bit positions (software visible)
  localparam int CTL_EN    = 0;
  localparam int CTL_GO    = 1;
  localparam int CTL_TRIG  = 2;
  localparam int CTL_OVCLR = 3;
  localparam int CTL_W     = 4;

  typedef struct packed {
    logic ovf;
    logic nointr;
    logic run;
  } bgt_stat_t;
endpackage

// File: rtl/bgt_cfg.sv
module bgt_cfg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] start_addr,
  output logic              en,
  output logic              trig_en,
  output logic              go_wr,
  output logic              ovclr_wr
);
  import bgt_pkg::*;

  logic              ctl_wr, addr_wr;
  logic [ADDR_W-1:0] sa_q, sa_n;
  logic              en_q, en_n, tg_q, tg_n;

  assign addr_wr  = wr_en & ~wr_sel;
  assign ctl_wr   = wr_en &  wr_sel;
  assign go_wr    = ctl_wr & wr_data[CTL_GO];
  assign ovclr_wr = ctl_wr & wr_data[CTL_OVCLR];

  always_comb begin
    sa_n = sa_q;
    en_n = en_q;
    tg_n = tg_q;
    if (addr_wr) sa_n = wr_data[ADDR_W-1:0];
    if (ctl_wr) begin
      en_n = wr_data[CTL_EN];
      tg_n = wr_data[CTL_TRIG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
      en_q <= 1'b0;
      tg_q <= 1'b0;
    end else begin
      sa_q <= sa_n;
      en_q <= en_n;
      tg_q <= tg_n;
    end
  end

  assign start_addr = sa_q;
  assign en         = en_q;
  assign trig_en    = tg_q;
endmodule

// File: rtl/bgt_seq.sv
module bgt_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              trig_en,
  input  logic              go_wr,
  input  logic              ovclr_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              fg_pending,
  input  logic              hw_trig,
  input  logic              task_done,
  input  logic              mask_cmd,
  input  logic              unmask_cmd,
  input  logic [ADDR_W-1:0] core_pc,
  output logic              launch_valid,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              preempt,
  output bgt_pkg::bgt_stat_t stat,
  output logic [ADDR_W-1:0] active_addr
);
  import bgt_pkg::*;

  bgt_state_e        st_q, st_n;
  logic              go_q, go_n, ovf_q, ovf_n, ni_q, ni_n;
  logic              lv_q, lv_n, pre_q, pre_n;
  logic [ADDR_W-1:0] la_q, la_n, act_q, act_n;
  logic              done_eff, trig_ok, fire_new, fire_res, pre_now;

  assign done_eff = task_done & (st_q == ST_RUN);
  assign trig_ok  = hw_trig & trig_en;
  assign fire_new = (st_q == ST_IDLE) & go_q & en & ~fg_pending;
  assign fire_res = (st_q == ST_HELD) & en & ~fg_pending;
  assign pre_now  = (st_q == ST_RUN) & ~done_eff & fg_pending & ~ni_q;

  always_comb begin
    st_n  = st_q;
    go_n  = (go_q & ~done_eff) | go_wr | trig_ok;
    ovf_n = ovf_q;
    if (ovclr_wr) ovf_n = 1'b0;
    if (trig_ok & go_q & ~done_eff) ovf_n = 1'b1;
    ni_n  = ni_q;
    lv_n  = fire_new | fire_res;
    pre_n = pre_now;
    la_n  = la_q;
    act_n = act_q;
    unique case (st_q)
      ST_IDLE: if (fire_new) begin
        st_n = ST_RUN;
        la_n = start_addr;
      end
      ST_RUN: begin
        if (done_eff) begin
          st_n = ST_IDLE;
          ni_n = 1'b0;
        end else if (pre_now) begin
          st_n  = ST_HELD;
          act_n = core_pc;
        end else if (mask_cmd) begin
          ni_n = 1'b1;
        end else if (unmask_cmd) begin
          ni_n = 1'b0;
        end
      end
      ST_HELD: if (fire_res) begin
        st_n = ST_RUN;
        la_n = act_q;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      go_q  <= 1'b0;
      ovf_q <= 1'b0;
      ni_q  <= 1'b0;
      lv_q  <= 1'b0;
      pre_q <= 1'b0;
      la_q  <= '0;
      act_q <= '0;
    end else begin
      st_q  <= st_n;
      go_q  <= go_n;
      ovf_q <= ovf_n;
      ni_q  <= ni_n;
      lv_q  <= lv_n;
      pre_q <= pre_n;
      la_q  <= la_n;
      act_q <= act_n;
    end
  end

  assign launch_valid = lv_q;
  assign launch_addr  = la_q;
  assign preempt      = pre_q;
  assign active_addr  = act_q;
  assign stat.ovf     = ovf_q;
  assign stat.nointr  = ni_q;
  assign stat.run     = (st_q != ST_IDLE);

  // R2
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_q) |-> $past(en && !fg_pending));
  // R7
  launch_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> (st_q == ST_RUN));
  // R9
  preempt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_q) |-> (act_q == $past(core_pc)) && (st_q == ST_HELD));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_q) |-> $past(ovclr_wr));
  // R8
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && ni_q) |=> !pre_q);
  // R11
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_eff && !go_wr && !trig_ok) |=> (!go_q && st_q == ST_IDLE && !ni_q));
endmodule

// File: rtl/bg_task_ctrl.sv
module bg_task_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fg_pending,
  input  logic              hw_trig,
  input  logic              task_done,
  input  logic              mask_cmd,
  input  logic              unmask_cmd,
  input  logic [ADDR_W-1:0] core_pc,
  output logic              launch_valid,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              preempt,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] active_addr
);
  import bgt_pkg::*;

  logic [ADDR_W-1:0] start_addr;
  logic              en, trig_en, go_wr, ovclr_wr;
  bgt_stat_t         stat;

  bgt_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start_addr(start_addr), .en(en), .trig_en(trig_en),
    .go_wr(go_wr), .ovclr_wr(ovclr_wr)
  );

  bgt_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .trig_en(trig_en), .go_wr(go_wr),
    .ovclr_wr(ovclr_wr), .start_addr(start_addr), .fg_pending(fg_pending),
    .hw_trig(hw_trig), .task_done(task_done), .mask_cmd(mask_cmd),
    .unmask_cmd(unmask_cmd), .core_pc(core_pc), .launch_valid(launch_valid),
    .launch_addr(launch_addr), .preempt(preempt), .stat(stat),
    .active_addr(active_addr)
  );

  assign status = stat;
endmodule

// File: tb/bg_task_ctrl_tb.sv
`timescale 1ns/1ps
module bg_task_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        fg_pending = 1'b0, hw_trig = 1'b0, task_done = 1'b0;
  logic        mask_cmd = 1'b0, unmask_cmd = 1'b0;
  logic [15:0] core_pc = '0;
  logic        launch_valid, preempt;
  logic [15:0] launch_addr, active_addr;
  logic [2:0]  status;

  int checks = 0, errors = 0;
  int launch_cnt = 0, preempt_cnt = 0;
  logic [15:0] last_la = '0;

  always #2.5 clk = ~clk;

  bg_task_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fg_pending(fg_pending), .hw_trig(hw_trig), .task_done(task_done),
    .mask_cmd(mask_cmd), .unmask_cmd(unmask_cmd), .core_pc(core_pc),
    .launch_valid(launch_valid), .launch_addr(launch_addr), .preempt(preempt),
    .status(status), .active_addr(active_addr)
  );

  // behavioural reference: 0 idle, 1 running, 2 suspended
  int          m_mode;
  bit          m_en, m_tg, m_go, m_ovf, m_lock, m_lv, m_pre;
  logic [15:0] m_sa, m_la, m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_en = 0; m_tg = 0; m_go = 0; m_ovf = 0; m_lock = 0;
      m_lv = 0; m_pre = 0; m_sa = 0; m_la = 0; m_act = 0;
    end else begin
      bit fin, trg, new_go, new_ovf, new_lock, new_lv, new_pre, new_en, new_tg;
      int new_mode;
      logic [15:0] new_la, new_act, new_sa;
      fin = task_done && m_mode == 1;
      trg = hw_trig && m_tg;
      new_go = (m_go && !fin) || (wr_en && wr_sel && wr_data[1]) || trg;
      new_ovf = m_ovf;
      if (wr_en && wr_sel && wr_data[3]) new_ovf = 0;
      if (trg && m_go && !fin) new_ovf = 1;
      new_mode = m_mode; new_lock = m_lock; new_lv = 0; new_pre = 0;
      new_la = m_la; new_act = m_act;
      if (m_mode == 0) begin
        if (m_go && m_en && !fg_pending) begin new_mode = 1; new_lv = 1; new_la = m_sa; end
      end else if (m_mode == 1) begin
        if (fin) begin new_mode = 0; new_lock = 0; end
        else if (fg_pending && !m_lock) begin new_mode = 2; new_pre = 1; new_act = core_pc; end
        else if (mask_cmd) new_lock = 1;
        else if (unmask_cmd) new_lock = 0;
      end else begin
        if (m_en && !fg_pending) begin new_mode = 1; new_lv = 1; new_la = m_act; end
      end
      new_en = m_en; new_tg = m_tg; new_sa = m_sa;
      if (wr_en && !wr_sel) new_sa = wr_data;
      if (wr_en && wr_sel) begin new_en = wr_data[0]; new_tg = wr_data[2]; end
      m_mode = new_mode; m_go = new_go; m_ovf = new_ovf; m_lock = new_lock;
      m_lv = new_lv; m_pre = new_pre; m_la = new_la; m_act = new_act;
      m_en = new_en; m_tg = new_tg; m_sa = new_sa;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R2 launch_valid", {15'd0, launch_valid}, {15'd0, m_lv});
    if (m_lv) chk("R2/R10 launch_addr", launch_addr, m_la);
    chk("R9 preempt", {15'd0, preempt}, {15'd0, m_pre});
    chk("R7 status", {13'd0, status}, {13'd0, m_mode != 0 ? 1'b1 : 1'b0} | {13'd0, m_ovf, m_lock, 1'b0});
    chk("R9 active_addr", active_addr, m_act);
    if (launch_valid) begin launch_cnt++; last_la = launch_addr; end
    if (preempt) preempt_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); #1; wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); #1; wr_en = 0;
  endtask
  task automatic pulse_trig();   @(negedge clk); #1; hw_trig = 1;    @(negedge clk); #1; hw_trig = 0;    endtask
  task automatic pulse_done();   @(negedge clk); #1; task_done = 1;  @(negedge clk); #1; task_done = 0;  endtask
  task automatic pulse_mask();   @(negedge clk); #1; mask_cmd = 1;   @(negedge clk); #1; mask_cmd = 0;   endtask
  task automatic pulse_unmask(); @(negedge clk); #1; unmask_cmd = 1; @(negedge clk); #1; unmask_cmd = 0; endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 status", {13'd0, status}, 16'd0);
    chk("R1 active_addr", active_addr, 16'd0);
    chk("R1 launch", {15'd0, launch_valid | preempt}, 16'd0);

    wr(0, 16'h1234);
    wr(1, 16'h0001);
    cyc(3);
    chk("R2 no launch without start", launch_cnt[15:0], 16'd0);

    fg_pending = 1;
    wr(1, 16'h0003);
    cyc(4);
    chk("R3 launch held by foreground", launch_cnt[15:0], 16'd0);
    fg_pending = 0;
    cyc(3);
    chk("R3 launch after release", launch_cnt[15:0], 16'd1);
    chk("R2 fresh launch address", last_la, 16'h1234);
    chk("R7 running", {13'd0, status}, 16'h0001);

    pulse_mask();
    cyc(2);
    chk("R8 locked", {13'd0, status}, 16'h0003);
    core_pc = 16'hBEEF;
    fg_pending = 1;
    cyc(4);
    chk("R8 no preempt while locked", preempt_cnt[15:0], 16'd0);
    pulse_unmask();
    cyc(3);
    chk("R9 preempt count", preempt_cnt[15:0], 16'd1);
    chk("R9 captured pc", active_addr, 16'hBEEF);
    chk("R7 running while held", {13'd0, status}, 16'h0001);
    fg_pending = 0;
    cyc(3);
    chk("R10 resume count", launch_cnt[15:0], 16'd2);
    chk("R10 resume address", last_la, 16'hBEEF);

    pulse_trig();
    cyc(2);
    chk("R4 trigger ignored when not allowed", {13'd0, status}, 16'h0001);
    wr(1, 16'h0005);
    pulse_trig();
    cyc(2);
    chk("R5 overflow on busy trigger", {13'd0, status}, 16'h0005);

    pulse_done();
    cyc(2);
    chk("R11 done ends run", {13'd0, status}, 16'h0004);
    cyc(4);
    chk("R11 no relaunch", launch_cnt[15:0], 16'd2);

    pulse_trig();
    cyc(4);
    chk("R4 trigger launches", launch_cnt[15:0], 16'd3);
    chk("R4 trigger launch address", last_la, 16'h1234);

    pulse_mask();
    cyc(2);
    chk("R8 locked again", {13'd0, status}, 16'h0007);
    pulse_done();
    cyc(2);
    chk("R8 done drops lock", {13'd0, status}, 16'h0004);

    wr(1, 16'h0001);
    cyc(2);
    chk("R6 overflow kept by plain write", {13'd0, status}, 16'h0004);
    wr(1, 16'h0009);
    cyc(2);
    chk("R6 overflow cleared", {13'd0, status}, 16'h0000);

    wr(0, 16'hFFFF);
    wr(1, 16'h0003);
    cyc(4);
    chk("R12 full-width address", last_la, 16'hFFFF);
    chk("R12 launch count", launch_cnt[15:0], 16'd4);
    pulse_done();
    cyc(3);
    chk("R11 idle at end", {13'd0, status}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule